// File: doc/BRIEF.md
# Segment Register Load Protection Checker

This block decides whether a protected-mode load of a 16-bit selector into one of the five loadable segment registers may go ahead. A request names the target register, the selector and the current privilege level. Two cases are settled without touching memory: a null selector, and a selector whose descriptor lies past the end of its table. Every other request fetches the descriptor's access-rights byte through a simple request/acknowledge read port. That byte is then judged against one rule set for the stack register and another for the four data registers.

A load that passes writes the selector and the access-rights byte into a per-register cache, which can be inspected through a lookup port. A load that fails reports one fault class and a 16-bit error code, and leaves the cache untouched. A successful stack-register load also raises an interrupt-inhibit flag, which stays up until the next instruction retires.

Top module: `segload_guard`

## Requirements
- R1: A selector whose bits 15:2 are all zero is null. A null load into a data register (codes 1 to 4: DS, ES, FS, GS) completes without a fault and without a descriptor read. It stores the selector, stores an access byte of zero and clears that register's valid bit.
- R2: A null load into the stack register (code 0) completes with fault class 1 (general protection) and error code 0x0000, without a descriptor read.
- R3: For a non-null selector, bit 2 chooses the limit: 0 selects `gdt_limit`, 1 selects `ldt_limit`. If (bits 15:3) × 8 + 7 exceeds that limit, the load completes with fault class 1 and the selector as error code, without a descriptor read.
- R4: The access byte is decoded as bit 7 present, bits 6:5 DPL, bit 4 code/data, bit 3 code, bit 2 conforming, bit 1 readable/writable. A stack load needs bit 4 = 1, bit 3 = 0 and bit 1 = 1, and both RPL (selector bits 1:0) and DPL must equal CPL. Otherwise it gets fault class 1 with the selector as error code.
- R5: A stack load that passes R4 but has bit 7 clear gets fault class 2 (stack fault) with the selector as error code.
- R6: A data-register load needs bit 4 = 1, and bit 1 = 1 if bit 3 = 1. Otherwise it gets fault class 1 with the selector as error code.
- R7: For a data-register load of a data segment or of non-conforming code, RPL ≤ DPL and CPL ≤ DPL must both hold, or the load gets fault class 1 with the selector as error code. Conforming code skips this check.
- R8: A data-register load that passes R6 and R7 but has bit 7 clear gets fault class 3 (not present) with the selector as error code.
- R9: Checks run in the order null, limit, type and privilege, present, and only the first failure is reported. A fault changes no cache entry.
- R10: `done` pulses in the cycle after the deciding edge (the request edge for null or limit cases, otherwise the acknowledge edge). A passing non-null load shows class 0, code 0, and on the lookup port the selector, the access byte and valid = 1.
- R11: `irq_inhibit` rises together with `done` of a passing stack load. It falls after the next edge that samples `insn_retire` high, unless another stack load commits at that same edge.
- R12: While a read is outstanding, `dsc_req` stays high with a constant `dsc_sel` until `dsc_ack`. New requests are ignored while busy, and requests with a register code above 4 are ignored at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | load request strobe |
| req_seg | input | 3 | target register code, 0 stack, 1..4 data |
| req_sel | input | 16 | selector to load |
| req_cpl | input | 2 | current privilege level |
| gdt_limit | input | LIM_W | global table limit in bytes |
| ldt_limit | input | LIM_W | local table limit in bytes |
| busy | output | 1 | descriptor read outstanding |
| dsc_req | output | 1 | descriptor read request |
| dsc_sel | output | 16 | selector of the descriptor to read |
| dsc_ack | input | 1 | read response strobe |
| dsc_ar | input | 8 | access-rights byte returned |
| done | output | 1 | one-cycle completion pulse |
| fault_class | output | 2 | 0 none, 1 general, 2 stack, 3 not present |
| fault_code | output | 16 | error code of the last completion |
| insn_retire | input | 1 | an instruction retired |
| irq_inhibit | output | 1 | interrupts held off |
| view_seg | input | 3 | register code to inspect |
| view_sel | output | 16 | cached selector |
| view_ar | output | 8 | cached access byte |
| view_vld | output | 1 | cached descriptor valid |

## Verification
The bench builds the block with LIM_W = 20. Table limits are therefore wider than any selector-derived offset, so a limit of 0x10000 must accept the highest index (offset 0xFFFF), while a small local-table limit rejects index 3 and accepts index 2. A behavioural model, rebuilt from the requirements, is compared on every clock for busy, the read port, completion, fault fields, the inhibit flag and the inspected cache entry. Directed loads cover every fault class, the priority between the type check and the present check, conforming code, and requests dropped while busy or with an illegal register code.

// File: rtl/segload_pkg.sv
package segload_pkg;
  localparam int SEL_W   = 16;
  localparam int AR_W    = 8;
  localparam int SEG_CNT = 5;
  localparam int SEG_W   = $clog2(SEG_CNT);

  localparam logic [SEG_W-1:0] SEG_SS = '0;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_STK  = 2'd2,
    FLT_NP   = 2'd3
  } flt_e;

  typedef struct packed {
    logic       present;
    logic [1:0] dpl;
    logic       cd;
    logic       code;
    logic       conf;
    logic       rw;
    logic       acc;
  } ar_t;
endpackage

// File: rtl/sel_screen.sv
module sel_screen #(
  parameter int SEL_W = 16,
  parameter int LIM_W = 16
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [LIM_W-1:0] gdt_lim,
  input  logic [LIM_W-1:0] ldt_lim,
  output logic             is_null,
  output logic             over_lim
);
  localparam int CMP_W = (LIM_W > SEL_W) ? LIM_W : SEL_W;

  logic [CMP_W-1:0] last_byte;
  logic [CMP_W-1:0] lim;

  always_comb begin
    last_byte = CMP_W'({sel[SEL_W-1:3], 3'b111});
    lim       = sel[2] ? CMP_W'(ldt_lim) : CMP_W'(gdt_lim);
    is_null   = (sel[SEL_W-1:2] == '0);
    over_lim  = (last_byte > lim);
  end
endmodule

// File: rtl/desc_judge.sv
module desc_judge
  import segload_pkg::*;
(
  input  logic       is_ss,
  input  logic [1:0] cpl,
  input  logic [1:0] rpl,
  input  ar_t        ar,
  output flt_e       verdict
);
  logic type_ok;
  logic priv_ok;
  flt_e miss_cls;

  always_comb begin
    if (is_ss) begin
      type_ok  = ar.cd && !ar.code && ar.rw;
      priv_ok  = (rpl == cpl) && (ar.dpl == cpl);
      miss_cls = FLT_STK;
    end else begin
      type_ok  = ar.cd && (!ar.code || ar.rw);
      priv_ok  = (ar.code && ar.conf) || ((rpl <= ar.dpl) && (cpl <= ar.dpl));
      miss_cls = FLT_NP;
    end
    if (!(type_ok && priv_ok)) verdict = FLT_GP;
    else if (!ar.present)      verdict = miss_cls;
    else                       verdict = FLT_NONE;
  end
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import segload_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEG_W-1:0]   wr_idx,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [AR_W-1:0]    wr_ar,
  input  logic               wr_vld,
  input  logic [SEG_W-1:0]   rd_idx,
  output logic [SEL_W-1:0]   rd_sel,
  output logic [AR_W-1:0]    rd_ar,
  output logic               rd_vld,
  output logic [SEG_CNT-1:0] vld_vec
);
  logic [SEL_W-1:0] sel_q [SEG_CNT];
  logic [AR_W-1:0]  ar_q  [SEG_CNT];

  for (genvar e = 0; e < SEG_CNT; e++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_en && (wr_idx == SEG_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[e]   <= '0;
        ar_q[e]    <= '0;
        vld_vec[e] <= 1'b0;
      end else if (ent_we) begin
        sel_q[e]   <= wr_sel;
        ar_q[e]    <= wr_ar;
        vld_vec[e] <= wr_vld;
      end
    end
  end

  always_comb begin
    rd_sel = '0;
    rd_ar  = '0;
    rd_vld = 1'b0;
    for (int e = 0; e < SEG_CNT; e++) begin
      if (rd_idx == SEG_W'(e)) begin
        rd_sel = sel_q[e];
        rd_ar  = ar_q[e];
        rd_vld = vld_vec[e];
      end
    end
  end
endmodule

// File: rtl/segload_guard.sv
module segload_guard
  import segload_pkg::*;
#(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_seg,
  input  logic [15:0]      req_sel,
  input  logic [1:0]       req_cpl,
  input  logic [LIM_W-1:0] gdt_limit,
  input  logic [LIM_W-1:0] ldt_limit,
  output logic             busy,
  output logic             dsc_req,
  output logic [15:0]      dsc_sel,
  input  logic             dsc_ack,
  input  logic [7:0]       dsc_ar,
  output logic             done,
  output logic [1:0]       fault_class,
  output logic [15:0]      fault_code,
  input  logic             insn_retire,
  output logic             irq_inhibit,
  input  logic [2:0]       view_seg,
  output logic [15:0]      view_sel,
  output logic [7:0]       view_ar,
  output logic             view_vld
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e              st_q, st_d;
  logic [SEL_W-1:0] lat_sel;
  logic [1:0]       lat_cpl;
  logic [SEG_W-1:0] lat_seg;
  logic             done_q, inh_q, inh_d;
  flt_e             cls_q, dec_cls, jdg_flt;
  logic [SEL_W-1:0] code_q, dec_code;
  logic             accept, dec, scr_null, scr_over;
  logic             wr_en, wr_vld;
  logic [SEG_W-1:0] wr_idx;
  logic [SEL_W-1:0] wr_sel;
  logic [AR_W-1:0]  wr_ar;
  logic [SEG_CNT-1:0] vld_vec;

  assign accept = (st_q == ST_IDLE) && req_valid && (req_seg < 3'(SEG_CNT));

  sel_screen #(.SEL_W(SEL_W), .LIM_W(LIM_W)) u_screen (
    .sel(req_sel), .gdt_lim(gdt_limit), .ldt_lim(ldt_limit),
    .is_null(scr_null), .over_lim(scr_over)
  );

  desc_judge u_judge (
    .is_ss(lat_seg == SEG_SS), .cpl(lat_cpl), .rpl(lat_sel[1:0]),
    .ar(ar_t'(dsc_ar)), .verdict(jdg_flt)
  );

  seg_cache u_cache (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_sel(wr_sel), .wr_ar(wr_ar), .wr_vld(wr_vld),
    .rd_idx(SEG_W'(view_seg)), .rd_sel(view_sel), .rd_ar(view_ar),
    .rd_vld(view_vld), .vld_vec(vld_vec)
  );

  // decision and next state
  always_comb begin
    st_d     = st_q;
    dec      = 1'b0;
    dec_cls  = FLT_NONE;
    dec_code = '0;
    wr_en    = 1'b0;
    wr_idx   = lat_seg;
    wr_sel   = lat_sel;
    wr_ar    = dsc_ar;
    wr_vld   = 1'b1;
    if (accept) begin
      if (scr_null) begin
        dec = 1'b1;
        if (SEG_W'(req_seg) == SEG_SS) begin
          dec_cls = FLT_GP;
        end else begin
          wr_en  = 1'b1;
          wr_idx = SEG_W'(req_seg);
          wr_sel = req_sel;
          wr_ar  = '0;
          wr_vld = 1'b0;
        end
      end else if (scr_over) begin
        dec      = 1'b1;
        dec_cls  = FLT_GP;
        dec_code = req_sel;
      end else begin
        st_d = ST_WAIT;
      end
    end else if ((st_q == ST_WAIT) && dsc_ack) begin
      st_d     = ST_IDLE;
      dec      = 1'b1;
      dec_cls  = jdg_flt;
      dec_code = (jdg_flt == FLT_NONE) ? '0 : lat_sel;
      wr_en    = (jdg_flt == FLT_NONE);
    end
    inh_d = inh_q;
    if (insn_retire) inh_d = 1'b0;
    if (wr_en && wr_vld && (wr_idx == SEG_SS)) inh_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      done_q  <= 1'b0;
      cls_q   <= FLT_NONE;
      code_q  <= '0;
      inh_q   <= 1'b0;
      lat_sel <= '0;
      lat_cpl <= '0;
      lat_seg <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= dec;
      inh_q  <= inh_d;
      if (dec) begin
        cls_q  <= dec_cls;
        code_q <= dec_code;
      end
      if (accept) begin
        lat_sel <= req_sel;
        lat_cpl <= req_cpl;
        lat_seg <= SEG_W'(req_seg);
      end
    end
  end

  assign busy        = (st_q == ST_WAIT);
  assign dsc_req     = (st_q == ST_WAIT);
  assign dsc_sel     = lat_sel;
  assign done        = done_q;
  assign fault_class = cls_q;
  assign fault_code  = code_q;
  assign irq_inhibit = inh_q;

  // R9: a reported fault leaves every valid bit as it was
  p_flt_keeps_cache_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_class != FLT_NONE) |-> $stable(vld_vec));
  // R5: stack fault class only for the stack register
  p_stk_only_ss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_class == FLT_STK) |-> (lat_seg == SEG_SS));
  // R8: not-present class only for data registers
  p_np_only_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_class == FLT_NP) |-> (lat_seg != SEG_SS));
  // R11: inhibit rises only with a clean stack completion
  p_inh_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_inhibit) |-> (done && fault_class == FLT_NONE && lat_seg == SEG_SS));
  // R12: read request held with a fixed selector until acknowledged
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_req && !dsc_ack) |=> (dsc_req && $stable(dsc_sel)));
endmodule

// File: tb/tb_segload_guard.sv
module tb_segload_guard;
  localparam int LIM_W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_seg = '0;
  logic [15:0] req_sel = '0;
  logic [1:0] req_cpl = '0;
  logic [LIM_W-1:0] gdt_limit = 20'h000FF;
  logic [LIM_W-1:0] ldt_limit = 20'h00017;
  logic dsc_ack = 1'b0;
  logic [7:0] dsc_ar = '0;
  logic insn_retire = 1'b0;
  logic [2:0] view_seg = '0;
  logic busy, dsc_req, done, irq_inhibit, view_vld;
  logic [15:0] dsc_sel, fault_code, view_sel;
  logic [1:0] fault_class;
  logic [7:0] view_ar;

  segload_guard #(.LIM_W(LIM_W)) dut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  int done_cnt = 0, read_cnt = 0;
  logic [1:0] got_cls;
  logic [15:0] got_code;
  logic prev_req = 1'b0;

  // behavioural reference state
  int m_busy, m_done, m_cls, m_code, m_inh, m_sel, m_cpl, m_seg;
  int m_csel[5], m_car[5], m_cvld[5];

  function automatic int judge(int seg, int cpl, int rpl, int ar);
    int p, dpl, s, cd, cf, rw;
    p = (ar >> 7) & 1; dpl = (ar >> 5) & 3; s = (ar >> 4) & 1;
    cd = (ar >> 3) & 1; cf = (ar >> 2) & 1; rw = (ar >> 1) & 1;
    if (seg == 0) begin
      if (s == 0 || cd == 1 || rw == 0 || rpl != cpl || dpl != cpl) return 1;
      if (p == 0) return 2;
      return 0;
    end
    if (s == 0 || (cd == 1 && rw == 0)) return 1;
    if (!(cd == 1 && cf == 1) && (rpl > dpl || cpl > dpl)) return 1;
    if (p == 0) return 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cls = 0; m_code = 0; m_inh = 0;
      m_sel = 0; m_cpl = 0; m_seg = 0;
      for (int i = 0; i < 5; i++) begin m_csel[i] = 0; m_car[i] = 0; m_cvld[i] = 0; end
    end else begin
      int v, lim, ofs;
      m_done = 0;
      if (insn_retire) m_inh = 0;
      if (m_busy == 0) begin
        if (req_valid && req_seg < 5) begin
          m_sel = req_sel; m_cpl = req_cpl; m_seg = req_seg;
          lim = req_sel[2] ? int'(ldt_limit) : int'(gdt_limit);
          ofs = (int'(req_sel) / 8) * 8 + 7;
          if (int'(req_sel) < 4) begin
            m_done = 1; m_code = 0;
            if (m_seg == 0) m_cls = 1;
            else begin
              m_cls = 0; m_csel[m_seg] = m_sel; m_car[m_seg] = 0; m_cvld[m_seg] = 0;
            end
          end else if (ofs > lim) begin
            m_done = 1; m_cls = 1; m_code = m_sel;
          end else m_busy = 1;
        end
      end else if (dsc_ack) begin
        m_busy = 0; m_done = 1;
        v = judge(m_seg, m_cpl, m_sel % 4, int'(dsc_ar));
        m_cls = v;
        m_code = (v == 0) ? 0 : m_sel;
        if (v == 0) begin
          m_csel[m_seg] = m_sel; m_car[m_seg] = int'(dsc_ar); m_cvld[m_seg] = 1;
          if (m_seg == 0) m_inh = 1;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      check("R12 busy", int'(busy), m_busy);
      check("R12 dsc_req", int'(dsc_req), m_busy);
      if (m_busy != 0) check("R12 dsc_sel", int'(dsc_sel), m_sel);
      check("R10 done", int'(done), m_done);
      check("R9 class", int'(fault_class), m_cls);
      check("R3 code", int'(fault_code), m_code);
      check("R11 inhibit", int'(irq_inhibit), m_inh);
      if (view_seg < 5) begin
        check("R10 view_sel", int'(view_sel), m_csel[view_seg]);
        check("R10 view_ar", int'(view_ar), m_car[view_seg]);
        check("R1 view_vld", int'(view_vld), m_cvld[view_seg]);
      end
      if (done) begin done_cnt++; got_cls = fault_class; got_code = fault_code; end
      if (dsc_req && !prev_req) read_cnt++;
      prev_req = dsc_req;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=<100000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic load(input int seg, input int sel, input int cpl, input int ar, input int lat);
    @(negedge clk);
    req_valid = 1'b1; req_seg = 3'(seg); req_sel = 16'(sel); req_cpl = 2'(cpl);
    @(negedge clk);
    req_valid = 1'b0;
    if (dsc_req) begin
      repeat (lat) @(negedge clk);
      dsc_ack = 1'b1; dsc_ar = 8'(ar);
      @(negedge clk);
      dsc_ack = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic expect_res(input string tag, input int cnt0, input int rd0,
                            input int cls, input int code, input int reads);
    check({tag, " done seen"}, done_cnt - cnt0, 1);
    check({tag, " class"}, int'(got_cls), cls);
    check({tag, " code"}, int'(got_code), code);
    check({tag, " reads"}, read_cnt - rd0, reads);
  endtask

  initial begin
    int c0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset done", int'(done), 0);
    check("R11 reset inhibit", int'(irq_inhibit), 0);
    check("R12 reset busy", int'(busy), 0);

    // R10 / R3: last GDT index inside limit, data segment into DS
    view_seg = 3'd1;
    c0 = done_cnt; r0 = read_cnt;
    load(1, 16'h00F8, 0, 8'h92, 2);
    expect_res("R10 ds ok", c0, r0, 0, 0, 1);
    check("R10 ds sel", int'(view_sel), 16'h00F8);
    check("R10 ds vld", int'(view_vld), 1);
    // R1: null into DS clears valid, no read
    c0 = done_cnt; r0 = read_cnt;
    load(1, 16'h0002, 0, 0, 0);
    expect_res("R1 ds null", c0, r0, 0, 0, 0);
    check("R1 null sel", int'(view_sel), 16'h0002);
    check("R1 null vld", int'(view_vld), 0);
    // R2: null into SS
    view_seg = 3'd0;
    c0 = done_cnt; r0 = read_cnt;
    load(0, 16'h0003, 3, 0, 0);
    expect_res("R2 ss null", c0, r0, 1, 0, 0);
    check("R9 ss untouched", int'(view_vld), 0);
    // R3: limits
    c0 = done_cnt; r0 = read_cnt;
    load(2, 16'h0100, 0, 0, 0);
    expect_res("R3 gdt over", c0, r0, 1, 16'h0100, 0);
    c0 = done_cnt; r0 = read_cnt;
    load(2, 16'h0014, 0, 8'h92, 0);
    expect_res("R3 ldt in", c0, r0, 0, 0, 1);
    c0 = done_cnt; r0 = read_cnt;
    load(2, 16'h001C, 0, 0, 0);
    expect_res("R3 ldt over", c0, r0, 1, 16'h001C, 0);
    ldt_limit = 20'h10000;
    c0 = done_cnt; r0 = read_cnt;
    load(3, 16'hFFFC, 0, 8'h92, 1);
    expect_res("R3 wide limit", c0, r0, 0, 0, 1);
    // R4 / R5 / R11: stack register
    c0 = done_cnt; load(0, 16'h0011, 0, 8'h92, 0);
    expect_res("R4 rpl!=cpl", c0, read_cnt - 1, 1, 16'h0011, 1);
    c0 = done_cnt; load(0, 16'h0010, 0, 8'hB2, 0);
    expect_res("R4 dpl!=cpl", c0, read_cnt - 1, 1, 16'h0010, 1);
    c0 = done_cnt; load(0, 16'h0010, 0, 8'h90, 0);
    expect_res("R4 read-only", c0, read_cnt - 1, 1, 16'h0010, 1);
    c0 = done_cnt; load(0, 16'h0010, 0, 8'h9A, 0);
    expect_res("R4 code seg", c0, read_cnt - 1, 1, 16'h0010, 1);
    c0 = done_cnt; load(0, 16'h0010, 0, 8'h12, 0);
    expect_res("R5 ss absent", c0, read_cnt - 1, 2, 16'h0010, 1);
    c0 = done_cnt; load(0, 16'h0010, 0, 8'h10, 0);
    expect_res("R9 type before present", c0, read_cnt - 1, 1, 16'h0010, 1);
    check("R9 ss still empty", int'(view_vld), 0);
    c0 = done_cnt; load(0, 16'h0013, 3, 8'hF2, 3);
    expect_res("R11 ss ok", c0, read_cnt - 1, 0, 0, 1);
    check("R11 inhibit up", int'(irq_inhibit), 1);
    repeat (3) @(negedge clk);
    check("R11 inhibit held", int'(irq_inhibit), 1);
    insn_retire = 1'b1; @(negedge clk); insn_retire = 1'b0;
    check("R11 inhibit cleared", int'(irq_inhibit), 0);
    // R6 / R7 / R8: data registers
    view_seg = 3'd4;
    c0 = done_cnt; load(4, 16'h0023, 3, 8'h9E, 0);
    expect_res("R7 conforming", c0, read_cnt - 1, 0, 0, 1);
    check("R7 conforming ar", int'(view_ar), 8'h9E);
    c0 = done_cnt; load(4, 16'h0020, 0, 8'h98, 0);
    expect_res("R6 exec-only", c0, read_cnt - 1, 1, 16'h0020, 1);
    c0 = done_cnt; load(4, 16'h0020, 0, 8'h82, 0);
    expect_res("R6 system", c0, read_cnt - 1, 1, 16'h0020, 1);
    c0 = done_cnt; load(4, 16'h0020, 3, 8'h92, 0);
    expect_res("R7 cpl>dpl", c0, read_cnt - 1, 1, 16'h0020, 1);
    c0 = done_cnt; load(4, 16'h0023, 0, 8'hB2, 0);
    expect_res("R7 rpl>dpl", c0, read_cnt - 1, 1, 16'h0023, 1);
    c0 = done_cnt; load(4, 16'h0023, 3, 8'h72, 0);
    expect_res("R8 absent", c0, read_cnt - 1, 3, 16'h0023, 1);
    check("R9 gs kept", int'(view_ar), 8'h9E);
    // R12: request while busy and illegal register code are dropped
    c0 = done_cnt; r0 = read_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_seg = 3'd2; req_sel = 16'h0030; req_cpl = 2'd0;
    @(negedge clk);
    req_seg = 3'd0; req_sel = 16'h0040;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 sel held", int'(dsc_sel), 16'h0030);
    dsc_ack = 1'b1; dsc_ar = 8'h92;
    @(negedge clk);
    dsc_ack = 1'b0;
    @(negedge clk);
    check("R12 one completion", done_cnt - c0, 1);
    check("R12 one read", read_cnt - r0, 1);
    view_seg = 3'd2;
    @(negedge clk);
    check("R12 first wins", int'(view_sel), 16'h0030);
    c0 = done_cnt; r0 = read_cnt;
    load(6, 16'h0050, 0, 0, 0);
    repeat (2) @(negedge clk);
    check("R12 bad code done", done_cnt - c0, 0);
    check("R12 bad code read", read_cnt - r0, 0);
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule